// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This engine converts a list of memory segments into the descriptor table that a bus-master disk DMA controller walks. Software or an upstream unit hands over segments one at a time, each as a 32-bit physical address and a 32-bit byte length, with a flag on the final segment of the list. The engine cuts each segment into chunks that never straddle a 64 KB address window and writes one descriptor per chunk into a descriptor RAM. Each write carries the entry index and both 32-bit words of the entry. Word 0 sits at byte offset 0 of the entry and word 1 at byte offset 4, both little-endian in memory.

In the normal encoding, a chunk that fills an entire 64 KB window is written as two 32 KB descriptors. Some controllers read a zero 16-bit count as zero bytes rather than 64 KB, so the 16-bit count field never holds 0x0000. The last descriptor of the table carries an end-of-table flag. A second encoding, selected per segment by `alt_mode_i`, suits controllers that count in 32-bit words. It places a word count minus one in the upper half of the count word, does not split full windows and sets no end flag.

When the list ends, the engine pulses `done_o` and reports either success with the number of descriptors written, or failure with a count of zero. Failure occurs when the table would exceed its capacity, or when the list produced no descriptors at all.

Top module: `sg_prd_builder`

## Requirements
- R1: In the normal encoding each descriptor is written as word 0 = chunk start address and word 1 = byte count in bits 15:0. Bits 30:16 of word 1 are zero. Descriptor k of a list is written at `wr_idx_o` = k.
- R2: No chunk crosses a 64 KB boundary. The chunk size is the smaller of (0x10000 minus address bits 15:0) and the remaining length. After each chunk the address advances by the chunk size and the remaining length shrinks by it, until the segment is used up. A zero-length segment yields no descriptor.
- R3: In the normal encoding, a chunk of exactly 0x10000 bytes is written as two descriptors: (address, 0x8000) and then (address+0x8000, 0x8000).
- R4: In the normal encoding, bit 31 of word 1 is set on the last descriptor of a successful table and clear on every other descriptor.
- R5: Capacity is checked before every descriptor, including the second half of a split. The capacity is the parameter MAX_ENTRIES, which defaults to 256. A list that needs more descriptors than this ends with `ok_o`=0 and `count_o`=0. A list that needs exactly MAX_ENTRIES succeeds.
- R6: A list that produces no descriptor (every segment has zero length) ends with `ok_o`=0 and `count_o`=0.
- R7: With `alt_mode_i`=1, word 1 holds ((bytes>>2)-1) in bits 31:16 and zero in bits 15:0. No end-of-table flag is set, and a full 64 KB chunk stays one descriptor (word 1 = 0x3FFF0000).
- R8: `seg_ready_o` is high only while the engine waits for a segment. A segment is taken on a clock edge where `seg_valid_i` and `seg_ready_o` are both high. `seg_ready_o` is low during every descriptor write.
- R9: `done_o` is a one-cycle pulse that comes with `ok_o` and `count_o`. `ok_o` and `count_o` hold their values until the next list completes.
- R10: The active-low reset clears the entry count and all result outputs. After reset, `seg_ready_o`=1, `wr_en_o`=0, `done_o`=0, `ok_o`=0 and `count_o`=0.
- R11: After an overflow, the remaining segments of the list are accepted and discarded. `done_o` comes only after the segment flagged last has been accepted, and the next list is processed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_mode_i | input | 1 | 1 selects the word-count encoding for the segment being accepted |
| seg_valid_i | input | 1 | Segment offered |
| seg_ready_o | output | 1 | Engine can take a segment |
| seg_addr_i | input | 32 | Segment physical start address |
| seg_len_i | input | 32 | Segment length in bytes |
| seg_last_i | input | 1 | Segment is the final one of the list |
| wr_en_o | output | 1 | Descriptor write strobe |
| wr_idx_o | output | $clog2(MAX_ENTRIES) | Descriptor entry index |
| wr_addr_word_o | output | 32 | Descriptor word 0 (address) |
| wr_cnt_word_o | output | 32 | Descriptor word 1 (count and flags) |
| done_o | output | 1 | One-cycle list completion pulse |
| ok_o | output | 1 | Table built successfully |
| count_o | output | $clog2(MAX_ENTRIES+1) | Number of descriptors in the table, 0 on failure |

## Verification
The assertions assume that `alt_mode_i` keeps one value for all segments of a list. They also assume that in the word-count encoding, segment addresses and lengths are multiples of 4, so no chunk is shorter than 4 bytes and the count field cannot wrap. The stimulus changes the mode only between lists and uses only word-aligned, word-multiple segments in that mode. Segment inputs are driven only while `seg_valid_i` is high, and are held until the accepting edge.

// File: rtl/sg_prd_pkg.sv
package sg_prd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_HALF,
    ST_FLUSH,
    ST_DRAIN
  } sg_state_e;

  localparam logic [16:0] WIN_BYTES  = 17'h1_0000;
  localparam logic [15:0] HALF_BYTES = 16'h8000;
  localparam int          EOT_BIT    = 31;
endpackage

// File: rtl/sg_chunk_calc.sv
module sg_chunk_calc
  import sg_prd_pkg::*;
(
  input  logic [31:0] addr_i,
  input  logic [31:0] len_i,
  output logic [16:0] bytes_o,
  output logic        full_o
);
  logic [16:0] room;

  always_comb begin
    room    = WIN_BYTES - {1'b0, addr_i[15:0]};
    bytes_o = (len_i < {15'd0, room}) ? len_i[16:0] : room;
    full_o  = bytes_o[16];
  end
endmodule

// File: rtl/sg_count_word.sv
module sg_count_word
  import sg_prd_pkg::*;
(
  input  logic        alt_i,
  input  logic [16:0] bytes_i,
  input  logic        half_i,
  output logic [31:0] word_o
);
  logic [15:0] words_m1;

  always_comb begin
    words_m1 = {1'b0, bytes_i[16:2]} - 16'd1;
    if (alt_i)       word_o = {words_m1, 16'h0000};
    else if (half_i) word_o = {16'h0000, HALF_BYTES};
    else             word_o = {16'h0000, bytes_i[15:0]};
  end
endmodule

// File: rtl/sg_prd_builder.sv
module sg_prd_builder
  import sg_prd_pkg::*;
#(
  parameter int MAX_ENTRIES = 256,
  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alt_mode_i,
  input  logic             seg_valid_i,
  output logic             seg_ready_o,
  input  logic [31:0]      seg_addr_i,
  input  logic [31:0]      seg_len_i,
  input  logic             seg_last_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [31:0]      wr_addr_word_o,
  output logic [31:0]      wr_cnt_word_o,
  output logic             done_o,
  output logic             ok_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_ENTRIES);

  sg_state_e        state_q;
  logic [31:0]      cur_addr_q, cur_len_q;
  logic             last_q, alt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      pend_addr_q, pend_word_q;
  logic             done_q, ok_q;
  logic [CNT_W-1:0] count_q;

  logic [16:0] chunk_bytes;
  logic        chunk_full, split, table_full, gen;
  logic [31:0] new_word;

  sg_chunk_calc u_chunk (
    .addr_i (cur_addr_q),
    .len_i  (cur_len_q),
    .bytes_o(chunk_bytes),
    .full_o (chunk_full)
  );

  assign split = chunk_full && !alt_q;

  sg_count_word u_word (
    .alt_i  (alt_q),
    .bytes_i(chunk_bytes),
    .half_i (split),
    .word_o (new_word)
  );

  assign table_full = (cnt_q == CAP);
  assign gen = !table_full &&
               ((state_q == ST_RUN && cur_len_q != 32'd0) || state_q == ST_HALF);

  // the pending entry is written once its successor exists, or at flush with the end flag
  assign wr_en_o        = (cnt_q != '0) && (gen || state_q == ST_FLUSH);
  assign wr_idx_o       = IDX_W'(cnt_q - 1'b1);
  assign wr_addr_word_o = pend_addr_q;
  assign wr_cnt_word_o  = pend_word_q |
                          ((state_q == ST_FLUSH && !alt_q) ? (32'd1 << EOT_BIT) : 32'd0);
  assign seg_ready_o    = (state_q == ST_IDLE) || (state_q == ST_DRAIN);

  assign done_o  = done_q;
  assign ok_o    = ok_q;
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_addr_q  <= '0;
      cur_len_q   <= '0;
      last_q      <= 1'b0;
      alt_q       <= 1'b0;
      cnt_q       <= '0;
      pend_addr_q <= '0;
      pend_word_q <= '0;
      done_q      <= 1'b0;
      ok_q        <= 1'b0;
      count_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (seg_valid_i) begin
            cur_addr_q <= seg_addr_i;
            cur_len_q  <= seg_len_i;
            last_q     <= seg_last_i;
            alt_q      <= alt_mode_i;
            state_q    <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (cur_len_q == 32'd0) begin
            state_q <= last_q ? ST_FLUSH : ST_IDLE;
          end else if (table_full) begin
            cnt_q <= '0;
            if (last_q) begin
              done_q  <= 1'b1;
              ok_q    <= 1'b0;
              count_q <= '0;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_DRAIN;
            end
          end else begin
            pend_addr_q <= cur_addr_q;
            pend_word_q <= new_word;
            cnt_q       <= cnt_q + 1'b1;
            if (split) begin
              state_q <= ST_HALF;
            end else begin
              cur_addr_q <= cur_addr_q + {15'd0, chunk_bytes};
              cur_len_q  <= cur_len_q - {15'd0, chunk_bytes};
            end
          end
        end
        ST_HALF: begin
          if (table_full) begin
            cnt_q <= '0;
            if (last_q) begin
              done_q  <= 1'b1;
              ok_q    <= 1'b0;
              count_q <= '0;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_DRAIN;
            end
          end else begin
            pend_addr_q <= cur_addr_q + {16'd0, HALF_BYTES};
            pend_word_q <= {16'd0, HALF_BYTES};
            cnt_q       <= cnt_q + 1'b1;
            cur_addr_q  <= cur_addr_q + {15'd0, WIN_BYTES};
            cur_len_q   <= cur_len_q - {15'd0, WIN_BYTES};
            state_q     <= ST_RUN;
          end
        end
        ST_FLUSH: begin
          done_q  <= 1'b1;
          ok_q    <= (cnt_q != '0);
          count_q <= cnt_q;
          cnt_q   <= '0;
          state_q <= ST_IDLE;
        end
        ST_DRAIN: begin
          if (seg_valid_i && seg_last_i) begin
            done_q  <= 1'b1;
            ok_q    <= 1'b0;
            count_q <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_prd_builder_chk.sv
module sg_prd_builder_chk #(
  parameter int MAX_ENTRIES = 256,
  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             seg_ready_o,
  input logic             wr_en_o,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic [31:0]      wr_addr_word_o,
  input logic [31:0]      wr_cnt_word_o,
  input logic             done_o,
  input logic             ok_o,
  input logic [CNT_W-1:0] count_o,
  input logic             alt_q
);
  logic [16:0] end_off;
  assign end_off = {1'b0, wr_addr_word_o[15:0]} + {1'b0, wr_cnt_word_o[15:0]};

  p_no_cross_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && !alt_q |-> end_off <= 17'h1_0000 && wr_cnt_word_o[15:0] != 16'd0);

  p_count_field_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && !alt_q |-> wr_cnt_word_o[30:16] == 15'd0);

  p_eot_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && !alt_q && wr_cnt_word_o[31] |=> done_o && ok_o);

  p_idx_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> {1'b0, wr_idx_o} < (IDX_W+1)'(MAX_ENTRIES));

  p_fail_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !ok_o |-> count_o == '0);

  p_ok_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && ok_o |-> count_o != '0 && count_o <= CNT_W'(MAX_ENTRIES));

  p_alt_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && alt_q |-> wr_cnt_word_o[15:0] == 16'd0 && !wr_cnt_word_o[31]);

  p_busy_on_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !seg_ready_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> done_o || ($stable(ok_o) && $stable(count_o)));
endmodule

bind sg_prd_builder sg_prd_builder_chk #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .seg_ready_o   (seg_ready_o),
  .wr_en_o       (wr_en_o),
  .wr_idx_o      (wr_idx_o),
  .wr_addr_word_o(wr_addr_word_o),
  .wr_cnt_word_o (wr_cnt_word_o),
  .done_o        (done_o),
  .ok_o          (ok_o),
  .count_o       (count_o),
  .alt_q         (alt_q)
);

// File: tb/sg_prd_builder_bench.sv
module sg_prd_builder_bench;
  localparam int MAXE = 256;
  localparam int IW   = 8;
  localparam int CW   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          alt_mode = 1'b0, seg_valid = 1'b0, seg_last = 1'b0;
  logic [31:0]   seg_addr = '0, seg_len = '0;
  logic          seg_ready, wr_en, done, ok;
  logic [IW-1:0] wr_idx;
  logic [31:0]   wr_aw, wr_cw;
  logic [CW-1:0] count;

  sg_prd_builder #(.MAX_ENTRIES(MAXE)) u_sg_prd_builder (
    .clk_i(clk), .rst_ni(rst_n), .alt_mode_i(alt_mode),
    .seg_valid_i(seg_valid), .seg_ready_o(seg_ready),
    .seg_addr_i(seg_addr), .seg_len_i(seg_len), .seg_last_i(seg_last),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_addr_word_o(wr_aw), .wr_cnt_word_o(wr_cw),
    .done_o(done), .ok_o(ok), .count_o(count)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0]   got_lo [MAXE];
  logic [31:0]   got_hi [MAXE];
  int            wr_cnt;
  bit            done_seen, got_ok, ready_err;
  logic [CW-1:0] got_n;
  logic [31:0]   exp_lo [MAXE];
  logic [31:0]   exp_hi [MAXE];
  int            exp_n;
  bit            exp_ok;
  logic [31:0]   sa [4];
  logic [31:0]   sl [4];
  int            ns;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (seg_ready) ready_err = 1'b1;
        got_lo[wr_idx] = wr_aw;
        got_hi[wr_idx] = wr_cw;
        wr_cnt++;
      end
      if (done) begin
        done_seen = 1'b1;
        got_ok    = ok;
        got_n     = count;
      end
    end
  end

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // expected table from the requirements
  task automatic build_exp(input bit m);
    exp_n  = 0;
    exp_ok = 1'b1;
    for (int s = 0; s < ns; s++) begin
      longint a = longint'(sa[s]);
      longint l = longint'(sl[s]);
      while (l > 0 && exp_ok) begin
        longint room = 65536 - (a & 'hFFFF);
        longint b = (l < room) ? l : room;
        if (!m && b == 65536) begin
          for (int h = 0; h < 2; h++) begin
            if (exp_n >= MAXE) exp_ok = 1'b0;
            else begin
              exp_lo[exp_n] = 32'(a + h * 32768);
              exp_hi[exp_n] = 32'h0000_8000;
              exp_n++;
            end
          end
        end else if (exp_n >= MAXE) exp_ok = 1'b0;
        else begin
          exp_lo[exp_n] = 32'(a);
          exp_hi[exp_n] = m ? 32'((((b >> 2) - 1) & 'hFFFF) << 16) : 32'(b);
          exp_n++;
        end
        a = a + b;
        l = l - b;
      end
    end
    if (exp_n == 0) exp_ok = 1'b0;
    if (exp_ok && !m) exp_hi[exp_n-1] = exp_hi[exp_n-1] | 32'h8000_0000;
  endtask

  task automatic send_seg(input logic [31:0] a, input logic [31:0] l,
                          input bit last, input bit m);
    @(negedge clk);
    while (!seg_ready) @(negedge clk);
    seg_valid = 1'b1; seg_addr = a; seg_len = l; seg_last = last; alt_mode = m;
    @(negedge clk);
    seg_valid = 1'b0;
  endtask

  task automatic run_list(input bit m, input string tag);
    int t;
    int bad;
    wr_cnt = 0; done_seen = 1'b0; ready_err = 1'b0;
    build_exp(m);
    for (int s = 0; s < ns; s++) begin
      if (s == ns - 1 && ns > 1)
        check(!done_seen, "R11", "done before last segment", done_seen, 0);
      send_seg(sa[s], sl[s], s == ns - 1, m);
    end
    t = 0;
    while (!done_seen && t < 2000) begin @(negedge clk); t++; end
    check(done_seen, tag, "done pulse", done_seen, 1);
    check(got_ok == exp_ok, tag, "ok flag", got_ok, exp_ok);
    check(got_n == CW'(exp_ok ? exp_n : 0), tag, "count", got_n, exp_ok ? exp_n : 0);
    if (exp_ok) begin
      check(wr_cnt == exp_n, tag, "writes", wr_cnt, exp_n);
      bad = -1;
      for (int k = exp_n - 1; k >= 0; k--)
        if (got_lo[k] !== exp_lo[k] || got_hi[k] !== exp_hi[k]) bad = k;
      if (bad >= 0)
        check(1'b0, tag, $sformatf("descriptor %0d word1", bad), got_hi[bad], exp_hi[bad]);
      else
        check(1'b1, tag, "descriptors", 0, 0);
    end
    check(!ready_err, "R8", "ready high during write", ready_err, 0);
    @(negedge clk);
    check(!done && ok == got_ok && count == got_n, "R9", "result held after pulse",
          {done, ok, 16'(count)}, {1'b0, got_ok, 16'(got_n)});
  endtask

  // {mode, addr, len, exp_ok, exp_count}
  localparam int NV = 9;
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 32'h0000_1000, 32'h0000_0200, 1'b1, 9'd1},
    {1'b0, 32'h0001_FF00, 32'h0000_0200, 1'b1, 9'd2},
    {1'b0, 32'h0003_0000, 32'h0001_0000, 1'b1, 9'd2},
    {1'b0, 32'h0004_8000, 32'h0001_8000, 1'b1, 9'd3},
    {1'b1, 32'h0005_0000, 32'h0001_0000, 1'b1, 9'd1},
    {1'b1, 32'h0006_FFF0, 32'h0000_0020, 1'b1, 9'd2},
    {1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0, 9'd0},
    {1'b0, 32'h0000_0010, 32'h0080_0000, 1'b1, 9'd256},
    {1'b0, 32'h0000_0000, 32'h0081_0000, 1'b0, 9'd0}
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R1";
      1, 3: return "R2";
      2: return "R3";
      4, 5: return "R7";
      6: return "R6";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(seg_ready && !wr_en && !done && !ok && count == 0, "R10", "reset outputs",
          {seg_ready, wr_en, done, ok}, 4'b1000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      ns = 1;
      sa[0] = VEC[i][73:42];
      sl[0] = VEC[i][41:10];
      run_list(VEC[i][74], vtag(i));
      check(got_ok == VEC[i][9] && got_n == VEC[i][8:0], vtag(i), "table result",
            {got_ok, 16'(got_n)}, {VEC[i][9], 16'(VEC[i][8:0])});
    end

    // multi-segment list with an empty segment in the middle
    ns = 3;
    sa[0] = 32'h0000_1000; sl[0] = 32'h80;
    sa[1] = 32'h0000_5000; sl[1] = 32'h0;
    sa[2] = 32'h0000_2000; sl[2] = 32'h100;
    run_list(1'b0, "R2");
    check(!got_hi[0][31] && got_hi[1][31], "R4", "end flag only on final entry",
          {got_hi[0][31], got_hi[1][31]}, 2'b01);

    // overflow on the second half of a split
    ns = 2;
    sa[0] = 32'h0000_0100; sl[0] = 32'h100;
    sa[1] = 32'h0001_0000; sl[1] = 32'h0080_0000;
    run_list(1'b0, "R5");

    // overflow mid-list, then drain of remaining segments
    ns = 3;
    sa[0] = 32'h0000_0000; sl[0] = 32'h0081_0000;
    sa[1] = 32'h0000_0100; sl[1] = 32'h10;
    sa[2] = 32'h0000_0200; sl[2] = 32'h10;
    run_list(1'b0, "R11");
    ns = 1;
    sa[0] = 32'h0000_3000; sl[0] = 32'h40;
    run_list(1'b0, "R11");

    // only empty segments
    ns = 2;
    sa[0] = 32'h0; sl[0] = 32'h0;
    sa[1] = 32'h10; sl[1] = 32'h0;
    run_list(1'b0, "R6");

    // good list, then reset in the middle of a long one
    ns = 1;
    sa[0] = 32'h0000_4000; sl[0] = 32'h20;
    run_list(1'b0, "R1");
    fork
      send_seg(32'h0, 32'h0040_0000, 1'b1, 1'b0);
    join
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(seg_ready && !wr_en && !done && !ok && count == 0, "R10", "mid-list reset",
          {seg_ready, wr_en, done, ok, 16'(count)}, {4'b1000, 16'd0});
    rst_n = 1'b1;
    ns = 1;
    sa[0] = 32'h0000_7FFC; sl[0] = 32'h8;
    run_list(1'b1, "R10");

    summary();
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    summary();
  end
endmodule